// File: doc/BRIEF.md
# Event Interrupt Status and Mask Controller

This block collects interrupt events from a timing card's reference monitors and turns them into one active-high interrupt request. It watches one validity flag per reference input, a small operating-state code and a one-cycle brief-loss pulse for the reference currently in use. A reference turning valid or invalid, or any change of the state code, produces an event. The brief-loss pulse produces an event directly. It reacts after only a couple of missed reference cycles, well before the slow validity monitor would declare the input invalid.

Events latch into a sticky status byte. A processor reads that byte through a simple synchronous port with address, write data, write strobe, read strobe and read data, and clears bits by writing ones. A mask byte selects which status bits may drive the request line. Status reads are served from a shadow copy taken when a read strobe begins, so the value returned stays fixed for the whole access.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the mask byte reads 0x00 and `irq_o` is low.
- R2: A write to address 1 replaces the whole 8-bit mask, and reading address 1 returns the last value written.
- R3: For reference i, a change of `ref_valid_i[i]` in either direction sets status bit i. The bit is visible from the second rising edge after the input changes.
- R4: Any change of `op_state_i` sets status bit NUM_REFS (bit 4 by default). Holding the same code sets nothing. Reading address 2 returns the sampled state code, zero-extended.
- R5: A high `brief_loss_i` at a rising edge sets status bit NUM_REFS+1 (bit 5 by default) at that edge.
- R6: A write to address 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R7: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq_o` is high exactly while some status bit is both set and enabled by a 1 in the same mask bit. It drops once every pending unmasked bit is cleared.
- R9: Reading address 0 returns a shadow copy of the status byte, taken at the first edge of a read strobe. The shadow does not change while the strobe stays high, even if new events arrive.
- R10: Bus writes never set status bits. Writes to addresses 2 and 3 have no effect. Address 3 and unused status bits read as 0.
- R11: A set status bit stays set until a write-one-to-clear removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid_i | input | NUM_REFS | Per-reference validity flags |
| op_state_i | input | STATE_W | Operating-state code |
| brief_loss_i | input | 1 | Brief-loss pulse for the selected reference |
| addr_i | input | 2 | Register address (0 status, 1 mask, 2 state, 3 spare) |
| wdata_i | input | 8 | Write data |
| wr_stb_i | input | 1 | Write strobe |
| rd_stb_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its defaults: four references and a 3-bit state code, which gives six live status bits. This small size makes full sweeps cheap. Every one of the 256 mask values is checked against a fully set status byte, and every one of the 64 clear patterns is checked against the live bits. Each reference is toggled in both directions, and the state code steps through all eight values. Separate cases make a clear collide with an event, and inject an event while a held read strobe is reading the shadow copy.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;
   localparam int REG_W  = 8;
   localparam int ADDR_W = 2;

   typedef logic [REG_W-1:0] reg_t;

   // Register map
   typedef enum logic [ADDR_W-1:0] {
      A_STATUS = 2'd0,
      A_MASK   = 2'd1,
      A_STATE  = 2'd2,
      A_SPARE  = 2'd3
   } addr_e;
endpackage

// File: rtl/evt_irq_change_det.sv
`timescale 1ns/1ps
// Samples a bus and flags bits that differ from the previous sample.
module evt_irq_change_det #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] samp_o,
   output logic [W-1:0] chg_o
);
   logic [W-1:0] samp_q;
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         samp_q <= '0;
         prev_q <= '0;
      end else begin
         samp_q <= din_i;
         prev_q <= samp_q;
      end
   end

   assign samp_o = samp_q;
   assign chg_o  = samp_q ^ prev_q;

   // R3
   chg_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> (samp_q == $past(din_i)));
endmodule

// File: rtl/evt_irq_sticky.sv
`timescale 1ns/1ps
// Sticky status bits: a set wins over a same-cycle clear.
module evt_irq_sticky #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] status_o
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)        bit_q <= 1'b0;
         else if (set_i[b]) bit_q <= 1'b1;
         else if (clr_i[b]) bit_q <= 1'b0;
      end
      assign status_o[b] = bit_q;
   end

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

   // R6
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> ((status_o & $past(clr_i) & ~$past(set_i)) == '0));

   // R11
   no_silent_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> (($past(status_o) & ~status_o & ~$past(clr_i)) == '0));

   // R10
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> ((status_o & ~$past(status_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/evt_irq_regs.sv
`timescale 1ns/1ps
// Bus-facing registers: mask, status shadow, clear decode and read mux.
module evt_irq_regs
   import evt_irq_pkg::*;
#(
   parameter int STATE_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_stb_i,
   input  logic               rd_stb_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  reg_t               wdata_i,
   input  reg_t               status_i,
   input  logic [STATE_W-1:0] state_i,
   output reg_t               mask_o,
   output reg_t               clr_o,
   output reg_t               rdata_o
);
   addr_e sel;
   logic  rd_q;
   reg_t  shadow_q;
   reg_t  mask_q;

   assign sel = addr_e'(addr_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q     <= 1'b0;
         shadow_q <= '0;
         mask_q   <= '0;
      end else begin
         rd_q <= rd_stb_i;
         if (rd_stb_i && !rd_q)
            shadow_q <= status_i;
         if (wr_stb_i && sel == A_MASK)
            mask_q <= wdata_i;
      end
   end

   assign clr_o  = (wr_stb_i && sel == A_STATUS) ? wdata_i : '0;
   assign mask_o = mask_q;

   always_comb begin
      unique case (sel)
         A_STATUS: rdata_o = shadow_q;
         A_MASK:   rdata_o = mask_q;
         A_STATE:  rdata_o = REG_W'(state_i);
         A_SPARE:  rdata_o = '0;
      endcase
   end

   // R9
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && rd_q) |=> $stable(shadow_q));

   // R2
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb_i && sel == A_MASK) |=> (mask_q == $past(wdata_i)));

   // R10
   mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb_i && sel == A_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/evt_irq_ctrl.sv
`timescale 1ns/1ps
module evt_irq_ctrl
   import evt_irq_pkg::*;
#(
   parameter int NUM_REFS = 4,
   parameter int STATE_W  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REFS-1:0] ref_valid_i,
   input  logic [STATE_W-1:0]  op_state_i,
   input  logic                brief_loss_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [REG_W-1:0]    wdata_i,
   input  logic                wr_stb_i,
   input  logic                rd_stb_i,
   output logic [REG_W-1:0]    rdata_o,
   output logic                irq_o
);
   localparam int EVT_W     = NUM_REFS + 2;
   localparam int BIT_STATE = NUM_REFS;
   localparam int BIT_BRIEF = NUM_REFS + 1;

   if (NUM_REFS < 1 || EVT_W > REG_W) begin : g_bad_refs
      $error("evt_irq_ctrl: NUM_REFS must leave room for two more status bits");
   end
   if (STATE_W < 1 || STATE_W > REG_W) begin : g_bad_state
      $error("evt_irq_ctrl: STATE_W must be 1..REG_W");
   end

   logic [NUM_REFS-1:0] ref_samp;
   logic [NUM_REFS-1:0] ref_chg;
   logic [STATE_W-1:0]  st_samp;
   logic [STATE_W-1:0]  st_chg;
   logic [EVT_W-1:0]    evt_set;
   logic [EVT_W-1:0]    status;
   reg_t                status_pad;
   reg_t                mask;
   reg_t                clr;

   evt_irq_change_det #(.W(NUM_REFS)) u_ref_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_i  (ref_valid_i),
      .samp_o (ref_samp),
      .chg_o  (ref_chg)
   );

   evt_irq_change_det #(.W(STATE_W)) u_state_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_i  (op_state_i),
      .samp_o (st_samp),
      .chg_o  (st_chg)
   );

   always_comb begin
      evt_set                 = '0;
      evt_set[NUM_REFS-1:0]   = ref_chg;
      evt_set[BIT_STATE]      = |st_chg;
      evt_set[BIT_BRIEF]      = brief_loss_i;
   end

   evt_irq_sticky #(.W(EVT_W)) u_sticky (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (evt_set),
      .clr_i    (clr[EVT_W-1:0]),
      .status_o (status)
   );

   assign status_pad = REG_W'(status);

   evt_irq_regs #(.STATE_W(STATE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb_i (wr_stb_i),
      .rd_stb_i (rd_stb_i),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .status_i (status_pad),
      .state_i  (st_samp),
      .mask_o   (mask),
      .clr_o    (clr),
      .rdata_o  (rdata_o)
   );

   assign irq_o = |(status_pad & mask);

   // R8
   irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (status != '0));

   // R3
   ref_event_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ref_chg) |=> ((status[NUM_REFS-1:0] & $past(ref_chg)) == $past(ref_chg)));

   // R1
   irq_quiet_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq_o);
endmodule

// File: tb/evt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module evt_irq_ctrl_bench;
   localparam int NR = 4;
   localparam int SW = 3;
   localparam logic [7:0] LIVE = 8'h3F;
   localparam logic [7:0] B_ST = 8'h10;
   localparam logic [7:0] B_BL = 8'h20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NR-1:0] ref_valid = '0;
   logic [SW-1:0] op_state = '0;
   logic          brief = 1'b0;
   logic [1:0]    addr = '0;
   logic [7:0]    wdata = '0;
   logic          wr_stb = 1'b0;
   logic          rd_stb = 1'b0;
   logic [7:0]    rdata;
   logic          irq;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   evt_irq_ctrl #(.NUM_REFS(NR), .STATE_W(SW)) u_evt_irq_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ref_valid_i  (ref_valid),
      .op_state_i   (op_state),
      .brief_loss_i (brief),
      .addr_i       (addr),
      .wdata_i      (wdata),
      .wr_stb_i     (wr_stb),
      .rd_stb_i     (rd_stb),
      .rdata_o      (rdata),
      .irq_o        (irq)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_stb = 1'b1;
      @(negedge clk);
      d = rdata;
      rd_stb = 1'b0;
   endtask

   task automatic fire_all();
      @(negedge clk);
      ref_valid = ~ref_valid;
      op_state  = op_state + 1'b1;
      brief     = 1'b1;
      @(negedge clk);
      brief = 1'b0;
      idle(2);
   endtask

   initial begin
      #500000;
      fails++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [7:0] d, d1, d2;
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk("R1 irq", {7'd0, irq}, 8'h00);
      rd(2'd0, d); chk("R1 status", d, 8'h00);
      rd(2'd1, d); chk("R1 mask", d, 8'h00);

      // R3 every reference, both directions; R11 stays set
      for (int i = 0; i < NR; i++) begin
         @(negedge clk); ref_valid[i] = 1'b1;
         idle(2);
         rd(2'd0, d); chk("R3 rise", d, 8'(1 << i));
         idle(5);
         rd(2'd0, d); chk("R11 sticky", d, 8'(1 << i));
         wr(2'd0, 8'(1 << i));
         rd(2'd0, d); chk("R6 clear", d, 8'h00);
         @(negedge clk); ref_valid[i] = 1'b0;
         idle(2);
         rd(2'd0, d); chk("R3 fall", d, 8'(1 << i));
         wr(2'd0, 8'hFF);
      end

      // R4 every state code, plus a held code
      for (int s = 1; s < 8; s++) begin
         @(negedge clk); op_state = SW'(s);
         idle(2);
         rd(2'd0, d); chk("R4 change", d, B_ST);
         rd(2'd2, d); chk("R4 state read", d, 8'(s));
         wr(2'd0, 8'hFF);
         @(negedge clk); op_state = SW'(s);
         idle(3);
         rd(2'd0, d); chk("R4 hold", d, 8'h00);
      end

      // R5 brief loss pulse
      @(negedge clk); brief = 1'b1;
      @(negedge clk); brief = 1'b0;
      rd(2'd0, d); chk("R5 brief", d, B_BL);
      wr(2'd0, 8'hFF);

      // R2 / R8 full mask sweep against all live bits set
      fire_all();
      rd(2'd0, d); chk("R10 unused bits", d, LIVE);
      for (int m = 0; m < 256; m++) begin
         wr(2'd1, 8'(m));
         rd(2'd1, d); chk("R2 mask readback", d, 8'(m));
         chk("R8 irq vs mask", {7'd0, irq}, {7'd0, |(8'(m) & LIVE)});
      end

      // R8 clearing drops the request
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'hFF);
      chk("R8 cleared", {7'd0, irq}, 8'h00);
      @(negedge clk); brief = 1'b1;
      @(negedge clk); brief = 1'b0;
      wr(2'd1, 8'h01);
      chk("R8 masked", {7'd0, irq}, 8'h00);
      wr(2'd1, B_BL);
      chk("R8 unmasked", {7'd0, irq}, 8'h01);
      wr(2'd0, 8'hFF);

      // R6 every clear pattern over the live bits
      for (int p = 0; p < 64; p++) begin
         fire_all();
         wr(2'd0, 8'(p));
         rd(2'd0, d); chk("R6 pattern", d, LIVE & ~8'(p));
         wr(2'd0, 8'hFF);
      end

      // R7 event and clear in the same cycle
      fire_all();
      @(negedge clk);
      addr = 2'd0; wdata = 8'h21; wr_stb = 1'b1; brief = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0; brief = 1'b0;
      rd(2'd0, d); chk("R7 set wins", d, 8'h3E);
      wr(2'd0, 8'hFF);

      // R9 shadow holds while the strobe is held
      @(negedge clk); ref_valid[0] = ~ref_valid[0];
      idle(2);
      @(negedge clk); addr = 2'd0; rd_stb = 1'b1;
      @(negedge clk); d1 = rdata; brief = 1'b1;
      @(negedge clk); brief = 1'b0;
      @(negedge clk); d2 = rdata; rd_stb = 1'b0;
      chk("R9 first", d1, 8'h01);
      chk("R9 held", d2, 8'h01);
      rd(2'd0, d); chk("R9 new read", d, 8'h21);
      wr(2'd0, 8'hFF);

      // R10 writes that must not take effect
      wr(2'd1, 8'h5A);
      wr(2'd0, 8'hFF);
      rd(2'd0, d); chk("R10 no set by write", d, 8'h00);
      wr(2'd2, 8'h55);
      rd(2'd2, d); chk("R10 state write", d, 8'(op_state));
      wr(2'd3, 8'hAA);
      rd(2'd3, d); chk("R10 spare", d, 8'h00);
      rd(2'd1, d); chk("R10 mask kept", d, 8'h5A);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule